// File: doc/BRIEF.md
# SM3 TT2 Round Step Unit

This unit computes one slice of the SM3 compression round on a packed four-lane state. Each accepted operation takes three 128-bit vectors and a 2-bit lane index. The first vector is the working state. The second vector supplies its top lane only. The third vector supplies one message word, chosen by the index.

The unit builds a new 32-bit word in three stages. It forms the XOR of the three upper state lanes. It adds that value to the lowest state lane, the top lane of the second vector and the chosen message word. It then passes the sum through the P0 permutation. The new word becomes the top lane of the result. The three lower result lanes are the remaining state lanes moved down by one position, and the middle one of them is rotated on the way.

Operands enter on a valid/ready handshake. The result sits in a single output register, which can take a new operand in the same cycle that the old result drains. This keeps a rate of one operation per cycle.

Top module: `sm3_tt2_step`

## Requirements
- R1: A synchronous active-high `rst` makes `out_valid` low at the next clock edge, whatever the state was before.
- R2: Result bits 127:96 equal P0(s), with P0(x) = x ^ rotl(x,9) ^ rotl(x,17). Here s = (acc[63:32] ^ acc[95:64] ^ acc[127:96]) + acc[31:0] + aux[127:96] + m, summed modulo 2^32.
- R3: The message word m is lane `lane_sel` of `msg_vec`. Index 0 takes bits 31:0, 1 takes bits 63:32, 2 takes bits 95:64 and 3 takes bits 127:96.
- R4: Result bits 95:64 equal acc[127:96], unchanged.
- R5: Result bits 63:32 equal acc[95:64] rotated left by 19.
- R6: Result bits 31:0 equal acc[63:32], unchanged.
- R7: Bits 95:0 of `aux_vec` and the unselected lanes of `msg_vec` have no effect on the result.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vec` keeps its value at the next edge.
- R10: An operand taken at a clock edge (`in_valid` and `in_ready` both high) shows on `out_vec` with `out_valid` high after that edge. A result drained with no new operand leaves `out_valid` low.
- R11: Carries out of bit 31 are dropped in every addition. For example, all-ones inputs give s = 0xFFFFFFFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| acc_vec | input | 128 | Working state, four 32-bit lanes |
| aux_vec | input | 128 | Second vector; only the top lane is used |
| msg_vec | input | 128 | Message vector, four 32-bit lanes |
| lane_sel | input | 2 | Message lane index |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vec | output | 128 | Updated state |

## Verification
The assertions assume that `rst` is high in the first cycle, and that the handshake inputs are known 0 or 1 after reset. The bench satisfies both: it holds reset from time zero and drives the inputs only at falling edges. The data properties sample the operand at the accepting edge, so the operands may change freely between offers. The stimulus randomises `in_valid`, `out_ready`, all three vectors and the index, and it places stalls and back-to-back operations at random. It also applies directed all-ones operands, per-index message patterns and a reset with a result pending.

// File: rtl/sm3_tt2_pkg.sv
package sm3_tt2_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int VEC_W  = WORD_W * LANES;
  localparam int SEL_W  = $clog2(LANES);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [VEC_W-1:0]  vec_t;

  function automatic word_t rotl(input word_t x, input int unsigned n);
    word_t r;
    r = (n == 0) ? x : ((x << n) | (x >> (WORD_W - n)));
    return r;
  endfunction

  function automatic word_t xor3(input word_t a, input word_t b, input word_t c);
    return a ^ b ^ c;
  endfunction

  function automatic word_t p0(input word_t x, input int unsigned ra, input int unsigned rb);
    return x ^ rotl(x, ra) ^ rotl(x, rb);
  endfunction

  function automatic word_t add4(input word_t a, input word_t b, input word_t c, input word_t d);
    word_t s;
    s = a + b;
    s = s + c;
    s = s + d;
    return s;
  endfunction

  function automatic word_t lane_of(input vec_t v, input int unsigned idx);
    return v[idx*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/tt2_lane_pick.sv
module tt2_lane_pick
  import sm3_tt2_pkg::*;
#(
  parameter int N_LANES = LANES,
  parameter int LW      = WORD_W,
  localparam int IW     = $clog2(N_LANES)
) (
  input  logic [N_LANES*LW-1:0] vec,
  input  logic [IW-1:0]         sel,
  output logic [LW-1:0]         word
);
  logic [LW-1:0] lanes [N_LANES];

  for (genvar g = 0; g < N_LANES; g++) begin : g_split
    assign lanes[g] = vec[g*LW +: LW];
  end

  assign word = lanes[sel];
endmodule

// File: rtl/tt2_new_word.sv
module tt2_new_word
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned ROT_A = 9,
  parameter int unsigned ROT_B = 17
) (
  input  vec_t  acc,
  input  word_t aux_top,
  input  word_t msg_word,
  output word_t mix,
  output word_t sum,
  output word_t word
);
  assign mix  = xor3(lane_of(acc, 1), lane_of(acc, 2), lane_of(acc, 3));
  assign sum  = add4(mix, lane_of(acc, 0), aux_top, msg_word);
  assign word = p0(sum, ROT_A, ROT_B);
endmodule

// File: rtl/tt2_lane_shuffle.sv
module tt2_lane_shuffle
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned ROT_MID = 19
) (
  input  vec_t  acc,
  input  word_t top_word,
  output vec_t  result
);
  assign result = {top_word,
                   lane_of(acc, 3),
                   rotl(lane_of(acc, 2), ROT_MID),
                   lane_of(acc, 1)};
endmodule

// File: rtl/tt2_hold_reg.sv
module tt2_hold_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_req,
  input  logic [W-1:0] d,
  input  logic         drain,
  output logic         accept,
  output logic         full,
  output logic [W-1:0] q
);
  logic take;

  assign accept = !full || drain;
  assign take   = load_req && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b1;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      q <= d;
    end
  end
endmodule

// File: rtl/sm3_tt2_step.sv
module sm3_tt2_step
  import sm3_tt2_pkg::*;
#(
  parameter int unsigned ROT_A   = 9,
  parameter int unsigned ROT_B   = 17,
  parameter int unsigned ROT_MID = 19
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC_W-1:0]   acc_vec,
  input  logic [VEC_W-1:0]   aux_vec,
  input  logic [VEC_W-1:0]   msg_vec,
  input  logic [SEL_W-1:0]   lane_sel,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   out_vec
);
  word_t msg_word_w;
  word_t mix_w;
  word_t sum_w;
  word_t top_w;
  vec_t  next_vec_w;
  logic  fire_w;
  logic  stall_w;

  tt2_lane_pick #(.N_LANES(LANES), .LW(WORD_W)) u_pick (
    .vec  (msg_vec),
    .sel  (lane_sel),
    .word (msg_word_w)
  );

  tt2_new_word #(.ROT_A(ROT_A), .ROT_B(ROT_B)) u_word (
    .acc      (acc_vec),
    .aux_top  (lane_of(aux_vec, LANES - 1)),
    .msg_word (msg_word_w),
    .mix      (mix_w),
    .sum      (sum_w),
    .word     (top_w)
  );

  tt2_lane_shuffle #(.ROT_MID(ROT_MID)) u_shuffle (
    .acc      (acc_vec),
    .top_word (top_w),
    .result   (next_vec_w)
  );

  tt2_hold_reg #(.W(VEC_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load_req (in_valid),
    .d        (next_vec_w),
    .drain    (out_ready),
    .accept   (in_ready),
    .full     (out_valid),
    .q        (out_vec)
  );

  assign fire_w  = in_valid && in_ready;
  assign stall_w = out_valid && !out_ready;
endmodule

// File: rtl/sm3_tt2_step_chk.sv
module sm3_tt2_step_chk
  import sm3_tt2_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] acc_vec,
  input logic             out_valid,
  input logic             out_ready,
  input logic [VEC_W-1:0] out_vec,
  input logic [WORD_W-1:0] sum,
  input logic             fire,
  input logic             stall
);
  AST_RESET_EMPTIES: assert property (@(posedge clk) rst |=> !out_valid); // R1
  AST_TOP_IS_P0: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_vec[127:96] == p0($past(sum), 9, 17)); // R2
  AST_PASS_HIGH: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_vec[95:64] == $past(acc_vec[127:96])); // R4
  AST_ROT_MID: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_vec[63:32] == rotl($past(acc_vec[95:64]), 19)); // R5
  AST_PASS_LOW: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_vec[31:0] == $past(acc_vec[63:32])); // R6
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    stall |-> !in_ready); // R8
  AST_EMPTY_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    stall |=> out_valid && $stable(out_vec)); // R9
  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid); // R10
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid); // R10
endmodule

bind sm3_tt2_step sm3_tt2_step_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .acc_vec   (acc_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec),
  .sum       (sum_w),
  .fire      (fire_w),
  .stall     (stall_w)
);

// File: tb/sm3_tt2_step_test.sv
module sm3_tt2_step_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [127:0] acc_vec = '0;
  logic [127:0] aux_vec = '0;
  logic [127:0] msg_vec = '0;
  logic [1:0]   lane_sel = '0;
  logic         in_ready;
  logic         out_valid;
  logic [127:0] out_vec;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [127:0] exp_q [$];
  logic [127:0] held_vec;
  bit           stalled_prev = 0;

  sm3_tt2_step uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .acc_vec(acc_vec), .aux_vec(aux_vec), .msg_vec(msg_vec), .lane_sel(lane_sel),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] rl(input logic [31:0] x, input int k);
    logic [63:0] dbl;
    dbl = {x, x} << k;
    return dbl[63:32];
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] m, input logic [1:0] s);
    longint unsigned tot;
    logic [31:0] t;
    logic [31:0] w;
    w = m >> (32 * s);
    tot = longint'(a[127:96] ^ a[95:64] ^ a[63:32]) + longint'(a[31:0])
        + longint'(b[127:96]) + longint'(w);
    t = tot[31:0];
    return {t ^ rl(t, 9) ^ rl(t, 17), a[127:96], rl(a[95:64], 19), a[63:32]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: called at a falling edge, returns at the next falling edge.
  task automatic step(input bit v, input bit r, input logic [127:0] a,
                      input logic [127:0] b, input logic [127:0] m, input logic [1:0] s);
    logic [127:0] e;
    bit rdy;
    check(out_valid == (exp_q.size() != 0), "R10 out_valid", 128'(out_valid),
          128'(exp_q.size() != 0));
    if (exp_q.size() != 0) begin
      e = exp_q[0];
      check(out_vec[127:96] == e[127:96], "R2 R3 R11 top lane", out_vec, e);
      check(out_vec[95:64] == e[95:64], "R4 lane 2", out_vec, e);
      check(out_vec[63:32] == e[63:32], "R5 lane 1", out_vec, e);
      check(out_vec[31:0] == e[31:0], "R6 lane 0", out_vec, e);
      if (stalled_prev) check(out_vec == held_vec, "R9 hold", out_vec, held_vec);
    end
    in_valid = v; out_ready = r; acc_vec = a; aux_vec = b; msg_vec = m; lane_sel = s;
    #1;
    rdy = (exp_q.size() == 0) || r;
    check(in_ready == rdy, "R8 in_ready", 128'(in_ready), 128'(rdy));
    stalled_prev = (exp_q.size() != 0) && !r;
    held_vec = out_vec;
    if (v && rdy) begin
      if (exp_q.size() != 0) void'(exp_q.pop_front());
      exp_q.push_back(model(a, b, m, s));
    end else if (r && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
    end
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] ra, rb, rm, oa, ob, base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(out_valid == 1'b0, "R1 reset empties", 128'(out_valid), 128'(0));
    check(in_ready == 1'b1, "R8 ready when empty", 128'(in_ready), 128'(1));

    // R11: all-ones operands force carries past bit 31
    step(1, 1, '1, '1, '1, 2'd1);
    step(0, 1, '0, '0, '0, 2'd0);

    // R3: distinct lanes, every index
    for (int k = 0; k < 4; k++) begin
      step(1, 1, 128'h0123_4567_89ab_cdef_1357_9bdf_2468_ace0,
           128'h1111_2222_3333_4444_5555_6666_7777_8888,
           128'h0000_0001_0000_0100_0001_0000_0100_0000, k[1:0]);
    end
    step(0, 1, '0, '0, '0, 2'd0);

    // R7: ignored aux lanes and unselected message lanes
    base = 128'hdead_beef_cafe_f00d_0bad_c0de_feed_face;
    step(1, 1, base, {32'h0f0f_0f0f, 96'h0}, {32'h0, 32'h1234_5678, 64'h0}, 2'd2);
    oa = out_vec;
    step(1, 1, base, {32'h0f0f_0f0f, 96'hffff_ffff_aaaa_aaaa_5555_5555},
         {32'h7777_7777, 32'h1234_5678, 64'h9999_9999_3333_3333}, 2'd2);
    ob = out_vec;
    check(oa == ob, "R7 ignored lanes", ob, oa);
    step(0, 1, '0, '0, '0, 2'd0);

    // R9: long stall then drain
    step(1, 0, base, base, base, 2'd3);
    repeat (4) step(1, 0, ~base, base, base, 2'd0);
    step(0, 1, '0, '0, '0, 2'd0);
    step(0, 1, '0, '0, '0, 2'd0);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rm = {$urandom, $urandom, $urandom, $urandom};
      step(($urandom % 4) != 0, ($urandom % 3) != 0, ra, rb, rm, 2'($urandom));
    end

    // R1: reset with a result pending
    step(1, 0, base, base, base, 2'd1);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    stalled_prev = 0;
    check(out_valid == 1'b0, "R1 reset with pending result", 128'(out_valid), 128'(0));
    step(0, 1, '0, '0, '0, 2'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule